// File: doc/BRIEF.md
# Stack and Call Frame Unit

This block keeps the stack pointer and the frame pointer of a 64-bit core whose stack grows toward lower addresses. The decode stage hands it one stack or call command at a time, with a register operand, a 16-bit immediate and the pc of the instruction. The unit turns the command into at most one data-memory access and then updates its pointers. Results go to the register file (pop) or to the pc (calls and return).

Memory is reached through a single request port: the unit raises a request and holds address, data, direction and size until the memory answers with ready. Read data is taken in the cycle of that handshake. While a sequence is in flight the unit reports busy, and any command offered in that time is dropped. Every command ends with a one-cycle done pulse, in the cycle after its completing clock edge.

Top module: `stack_frame_unit`

## Requirements
- R1: After reset, sp equals SP_RESET (default 0x10000), fp equals FP_RESET (default 0x10000), and done, rf_we, pc_we and mem_req_valid are all low.
- R2: Push register (op 1) writes cmd_opa as a full 64-bit access (mem_full=1, mem_we=1) to address sp-8, after which sp equals sp-8.
- R3: Op 2 writes the immediate sign-extended to 64 bits. Op 3 writes it zero-extended to 64 bits. Both use a full access at sp-8 and leave sp at sp-8. Op 4 writes the zero-extended immediate as a 16-bit access (mem_full=0) at sp-2 and leaves sp at sp-2.
- R4: Pop (op 5) reads a full word at sp. It then pulses rf_we together with done, with rf_wdata equal to the read data, and sp becomes sp+8.
- R5: Enter (op 6) writes the old fp as a full word at sp-8. Afterwards sp and fp both equal that address.
- R6: Leave (op 7) reads a full word at address fp. Afterwards sp equals the old fp plus 8 and fp equals the read data.
- R7: Reloc (op 8) makes no memory request. sp becomes cmd_opa and fp becomes cmd_opa minus the zero-extended immediate. done is high in the cycle after the command is accepted.
- R8: Call (op 9) writes cmd_pc+4 as a full word at sp-8 and leaves sp at sp-8. It then pulses pc_we with pc_wdata = cmd_pc + 4*sext(imm). Long call (op 10) does the same with target cmd_opa + 4*sext(imm).
- R9: Return (op 11) reads a full word at sp. It then pulses pc_we with pc_wdata equal to the read data, and sp becomes sp+8.
- R10: While mem_req_valid is high and mem_req_ready is low, the request fields stay unchanged and sp and fp do not change.
- R11: done is high for one cycle, after the handshake edge of a memory command or after the accept edge of a command without a memory access. busy is high from acceptance until the handshake. A command offered while busy is ignored: it causes no request, no rf_we and no change to sp.
- R12: Op 0 and the unused codes 12 to 15 complete without a request and leave sp and fp unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle; taken only while not busy |
| cmd_op | input | 4 | Command code (0 none, 1 push reg, 2 push sext, 3 push zext, 4 push 16-bit, 5 pop, 6 enter, 7 leave, 8 reloc, 9 call, 10 long call, 11 return) |
| cmd_opa | input | 64 | Register operand |
| cmd_imm | input | 16 | Immediate |
| cmd_pc | input | 64 | Address of the current instruction |
| busy | output | 1 | Memory sequence in progress |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts or answers the request this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_full | output | 1 | 1 for a 64-bit access, 0 for a 16-bit access |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data (16-bit data in the low bits) |
| mem_rdata | input | 64 | Read data, valid with mem_req_ready on a read |
| sp | output | 64 | Current stack pointer |
| fp | output | 64 | Current frame pointer |
| rf_we | output | 1 | Register-file write pulse (pop result) |
| rf_wdata | output | 64 | Value for the register file |
| pc_we | output | 1 | pc write pulse |
| pc_wdata | output | 64 | New pc |
| done | output | 1 | Command completed |

## Verification
A wrong pointer value shows at the sp and fp ports in the cycle after the completing edge. It also shows one command later as a wrong mem_addr, because each access address comes from the current pointers. A wrong held plan or state shows as a request field that moves during a stall, as a missing or extra done, or as a pulse on rf_we or pc_we for the wrong command. Each of these shows within one cycle of the handshake. The bench therefore checks the address, data and size of every access, and reads both pointers after every command, including the one dropped while busy.

// File: rtl/sfu_pkg.sv
// Shared types of the stack and call frame unit.
// Assumes a byte-addressed 64-bit data space and 16-bit immediates.
package sfu_pkg;
    localparam int unsigned XLEN       = 64;
    localparam int unsigned IMM_W      = 16;
    localparam int unsigned WORD_BYTES = XLEN / 8;
    localparam int unsigned HALF_BYTES = IMM_W / 8;
    localparam int unsigned OP_W       = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 4'd0,
        OP_PUSHR  = 4'd1,
        OP_PUSHS  = 4'd2,
        OP_PUSHZ  = 4'd3,
        OP_PUSHH  = 4'd4,
        OP_POP    = 4'd5,
        OP_ENTER  = 4'd6,
        OP_LEAVE  = 4'd7,
        OP_RELOC  = 4'd8,
        OP_CALL   = 4'd9,
        OP_LCALL  = 4'd10,
        OP_RET    = 4'd11
    } sfu_op_e;

    typedef enum logic [1:0] {FP_KEEP, FP_SET, FP_LOAD} fp_act_e;
    typedef enum logic [1:0] {DST_NONE, DST_RF, DST_PC_MEM, DST_PC_TGT} dst_e;

    typedef struct packed {
        logic            use_mem;
        logic            wr;
        logic            full;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] sp_new;
        logic [XLEN-1:0] fp_new;
        logic [XLEN-1:0] target;
        fp_act_e         fp_act;
        dst_e            dst;
    } sfu_plan_t;
endpackage

// File: rtl/sfu_decode.sv
// Turns a command and the current pointers into a plan: one optional
// memory access plus the pointer and result updates that follow it.
// Purely combinational; assumes sp/fp are the committed values.
module sfu_decode
    import sfu_pkg::*;
(
    input  sfu_op_e          op,
    input  logic [XLEN-1:0]  opa,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  sp,
    input  logic [XLEN-1:0]  fp,
    output sfu_plan_t        plan
);
    logic [XLEN-1:0] imm_s, imm_z, ofs4, sp_dn, sp_up, ret_addr;

    assign imm_s    = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_z    = {{(XLEN-IMM_W){1'b0}}, imm};
    assign ofs4     = imm_s << 2;
    assign sp_dn    = sp - XLEN'(WORD_BYTES);
    assign sp_up    = sp + XLEN'(WORD_BYTES);
    assign ret_addr = pc + XLEN'(4);

    // Build the plan for the offered command.
    always_comb begin
        plan         = '0;
        plan.full    = 1'b1;
        plan.addr    = sp;
        plan.sp_new  = sp;
        plan.fp_new  = fp;
        plan.target  = pc;
        plan.fp_act  = FP_KEEP;
        plan.dst     = DST_NONE;
        case (op)
            OP_PUSHR, OP_PUSHS, OP_PUSHZ, OP_ENTER, OP_CALL, OP_LCALL: begin
                plan.use_mem = 1'b1;
                plan.wr      = 1'b1;
                plan.addr    = sp_dn;
                plan.sp_new  = sp_dn;
                case (op)
                    OP_PUSHR: plan.wdata = opa;
                    OP_PUSHS: plan.wdata = imm_s;
                    OP_PUSHZ: plan.wdata = imm_z;
                    OP_ENTER: begin
                        plan.wdata  = fp;
                        plan.fp_new = sp_dn;
                        plan.fp_act = FP_SET;
                    end
                    OP_CALL: begin
                        plan.wdata  = ret_addr;
                        plan.target = pc + ofs4;
                        plan.dst    = DST_PC_TGT;
                    end
                    default: begin
                        plan.wdata  = ret_addr;
                        plan.target = opa + ofs4;
                        plan.dst    = DST_PC_TGT;
                    end
                endcase
            end
            OP_PUSHH: begin
                plan.use_mem = 1'b1;
                plan.wr      = 1'b1;
                plan.full    = 1'b0;
                plan.addr    = sp - XLEN'(HALF_BYTES);
                plan.sp_new  = sp - XLEN'(HALF_BYTES);
                plan.wdata   = imm_z;
            end
            OP_POP, OP_RET: begin
                plan.use_mem = 1'b1;
                plan.sp_new  = sp_up;
                plan.dst     = (op == OP_POP) ? DST_RF : DST_PC_MEM;
            end
            OP_LEAVE: begin
                plan.use_mem = 1'b1;
                plan.addr    = fp;
                plan.sp_new  = fp + XLEN'(WORD_BYTES);
                plan.fp_act  = FP_LOAD;
            end
            OP_RELOC: begin
                plan.sp_new = opa;
                plan.fp_new = opa - imm_z;
                plan.fp_act = FP_SET;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sfu_seq.sv
// Sequencer: accepts a plan when idle, holds it on the memory port until
// ready, then signals commit and registers done and the result pulses.
// Assumes read data is valid in the cycle of the handshake.
module sfu_seq
    import sfu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  sfu_plan_t       plan_in,
    output logic            busy,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_we,
    output logic            mem_full,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            commit,
    output sfu_plan_t       commit_plan,
    output logic            rf_we,
    output logic [XLEN-1:0] rf_wdata,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_wdata,
    output logic            done
);
    typedef enum logic {S_IDLE, S_MEM} seq_state_e;

    seq_state_e state_q;
    sfu_plan_t  plan_q;
    logic       accept;

    assign accept        = (state_q == S_IDLE) && cmd_valid;
    assign busy          = (state_q == S_MEM);
    assign mem_req_valid = busy;
    assign mem_we        = plan_q.wr;
    assign mem_full      = plan_q.full;
    assign mem_addr      = plan_q.addr;
    assign mem_wdata     = plan_q.wdata;
    assign commit        = (accept && !plan_in.use_mem) || (busy && mem_req_ready);
    assign commit_plan   = busy ? plan_q : plan_in;

    // State and held plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            plan_q  <= '0;
        end else if (accept && plan_in.use_mem) begin
            state_q <= S_MEM;
            plan_q  <= plan_in;
        end else if (busy && mem_req_ready) begin
            state_q <= S_IDLE;
        end
    end

    // Completion and result pulses, one cycle after commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rf_we    <= 1'b0;
            pc_we    <= 1'b0;
            rf_wdata <= '0;
            pc_wdata <= '0;
        end else begin
            done  <= commit;
            rf_we <= commit && (commit_plan.dst == DST_RF);
            pc_we <= commit && (commit_plan.dst inside {DST_PC_MEM, DST_PC_TGT});
            if (commit && commit_plan.dst == DST_RF)
                rf_wdata <= mem_rdata;
            if (commit && commit_plan.dst == DST_PC_MEM)
                pc_wdata <= mem_rdata;
            else if (commit && commit_plan.dst == DST_PC_TGT)
                pc_wdata <= commit_plan.target;
        end
    end

    // R10: a stalled request keeps all its fields.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata) &&
         $stable(mem_we) && $stable(mem_full)));

    // R11: every handshake is followed by done.
    a_r11_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> done);
endmodule

// File: rtl/sfu_ptr_regs.sv
// Holds sp and fp; updates them only on a commit of the sequencer.
// Assumes the commit plan carries final pointer values.
module sfu_ptr_regs
    import sfu_pkg::*;
#(
    parameter logic [XLEN-1:0] SP_RESET = 64'h1_0000,
    parameter logic [XLEN-1:0] FP_RESET = 64'h1_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  sfu_plan_t       plan,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] sp,
    output logic [XLEN-1:0] fp
);
    // Pointer update on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_RESET;
            fp <= FP_RESET;
        end else if (commit) begin
            sp <= plan.sp_new;
            case (plan.fp_act)
                FP_SET:  fp <= plan.fp_new;
                FP_LOAD: fp <= rdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stack_frame_unit.sv
// Top of the stack and call frame unit: decode, sequencer, pointer regs.
// Assumes one command at a time; commands offered while busy are dropped.
module stack_frame_unit
    import sfu_pkg::*;
#(
    parameter logic [XLEN-1:0] SP_RESET = 64'h1_0000,
    parameter logic [XLEN-1:0] FP_RESET = 64'h1_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [XLEN-1:0]  cmd_opa,
    input  logic [IMM_W-1:0] cmd_imm,
    input  logic [XLEN-1:0]  cmd_pc,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_we,
    output logic             mem_full,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  sp,
    output logic [XLEN-1:0]  fp,
    output logic             rf_we,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_wdata,
    output logic             done
);
    sfu_plan_t plan_in, commit_plan;
    logic      commit;

    sfu_decode i_decode (
        .op   (sfu_op_e'(cmd_op)),
        .opa  (cmd_opa),
        .imm  (cmd_imm),
        .pc   (cmd_pc),
        .sp   (sp),
        .fp   (fp),
        .plan (plan_in)
    );

    sfu_seq i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .plan_in       (plan_in),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_we        (mem_we),
        .mem_full      (mem_full),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .commit        (commit),
        .commit_plan   (commit_plan),
        .rf_we         (rf_we),
        .rf_wdata      (rf_wdata),
        .pc_we         (pc_we),
        .pc_wdata      (pc_wdata),
        .done          (done)
    );

    sfu_ptr_regs #(.SP_RESET(SP_RESET), .FP_RESET(FP_RESET)) i_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .plan   (commit_plan),
        .rdata  (mem_rdata),
        .sp     (sp),
        .fp     (fp)
    );

    // R2, R3: after any write handshake sp points at the written address.
    a_r2_write_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_we) |=> (sp == $past(mem_addr)));

    // R4: after any read handshake sp sits one word above the read address.
    a_r4_read_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_we) |=>
        (sp == $past(mem_addr) + XLEN'(WORD_BYTES)));

    // R4: a register-file write only follows a read handshake.
    a_r4_rf_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_req_valid && mem_req_ready && !mem_we));

    // R10: pointers stay put while a request is stalled.
    a_r10_ptr_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> ($stable(sp) && $stable(fp)));
endmodule

// File: tb/test_stack_frame_unit.sv
`timescale 1ns/1ps
module test_stack_frame_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [63:0] cmd_opa = '0;
    logic [15:0] cmd_imm = '0;
    logic [63:0] cmd_pc = '0;
    logic        busy, mem_req_valid, mem_req_ready, mem_we, mem_full;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [63:0] sp, fp, rf_wdata, pc_wdata;
    logic        rf_we, pc_we, done;

    int errors = 0;
    int checks = 0;
    int stall  = 0;
    int req_cnt = 0;
    int rf_cnt = 0;
    logic [63:0] rd_value = '0;
    logic [63:0] lw_addr, lw_data;
    logic        lw_we, lw_full;

    always #4 clk = ~clk;

    stack_frame_unit i_stack_frame_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_opa(cmd_opa), .cmd_imm(cmd_imm), .cmd_pc(cmd_pc), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_we(mem_we), .mem_full(mem_full), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp), .fp(fp),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .done(done)
    );

    // Behavioural memory: ready after 'stall' waiting cycles.
    assign mem_req_ready = mem_req_valid && (stall == 0);
    assign mem_rdata     = rd_value;

    always @(posedge clk) begin
        if (mem_req_valid && stall != 0) stall <= stall - 1;
        if (mem_req_valid && mem_req_ready) begin
            req_cnt <= req_cnt + 1;
            lw_addr <= mem_addr;
            lw_data <= mem_wdata;
            lw_we   <= mem_we;
            lw_full <= mem_full;
        end
        if (rf_we) rf_cnt <= rf_cnt + 1;
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [63:0] a,
                         input logic [15:0] im, input logic [63:0] p);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_opa = a; cmd_imm = im; cmd_pc = p;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R11 done seen", {63'd0, done}, 64'd1);
    endtask

    task automatic t_reset;
        chk("R1 sp", sp, 64'h1_0000);
        chk("R1 fp", fp, 64'h1_0000);
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 pulses", {62'd0, rf_we, pc_we}, 64'd0);
        chk("R1 req", {63'd0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_push_reg;
        issue(4'd1, 64'h1122_3344_5566_7788, 16'h0, 64'h0);
        chk("R2 addr", lw_addr, 64'hFFF8);
        chk("R2 data", lw_data, 64'h1122_3344_5566_7788);
        chk("R2 we/full", {62'd0, lw_we, lw_full}, 64'd3);
        chk("R2 sp", sp, 64'hFFF8);
    endtask

    task automatic t_push_imm;
        issue(4'd2, 64'h0, 16'h8001, 64'h0);
        chk("R3 sext data", lw_data, 64'hFFFF_FFFF_FFFF_8001);
        chk("R3 sext addr", lw_addr, 64'hFFF0);
        issue(4'd3, 64'h0, 16'h8001, 64'h0);
        chk("R3 zext data", lw_data, 64'h8001);
        chk("R3 zext addr", lw_addr, 64'hFFE8);
        issue(4'd4, 64'h0, 16'hBEEF, 64'h0);
        chk("R3 half data", lw_data, 64'hBEEF);
        chk("R3 half addr", lw_addr, 64'hFFE6);
        chk("R3 half full", {63'd0, lw_full}, 64'd0);
        chk("R3 half sp", sp, 64'hFFE6);
    endtask

    task automatic t_pop;
        rd_value = 64'hCAFE_F00D_1234_5678;
        issue(4'd5, 64'h0, 16'h0, 64'h0);
        chk("R4 addr", lw_addr, 64'hFFE6);
        chk("R4 read", {63'd0, lw_we}, 64'd0);
        chk("R4 rf_we", {63'd0, rf_we}, 64'd1);
        chk("R4 rf_wdata", rf_wdata, 64'hCAFE_F00D_1234_5678);
        chk("R4 sp", sp, 64'hFFEE);
    endtask

    task automatic t_reloc;
        int r0 = req_cnt;
        issue(4'd8, 64'h8000, 16'h0040, 64'h0);
        chk("R7 sp", sp, 64'h8000);
        chk("R7 fp", fp, 64'h7FC0);
        chk("R7 no req", 64'(req_cnt - r0), 64'd0);
    endtask

    task automatic t_enter;
        issue(4'd6, 64'h0, 16'h0, 64'h0);
        chk("R5 addr", lw_addr, 64'h7FF8);
        chk("R5 data", lw_data, 64'h7FC0);
        chk("R5 sp", sp, 64'h7FF8);
        chk("R5 fp", fp, 64'h7FF8);
    endtask

    task automatic t_stall_ignore;
        int r0 = req_cnt;
        int f0 = rf_cnt;
        int n = 0;
        stall = 3;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd1; cmd_opa = 64'hA5A5; cmd_imm = '0;
        @(negedge clk);
        cmd_op = 4'd5;
        chk("R11 busy", {63'd0, busy}, 64'd1);
        chk("R10 addr held", mem_addr, 64'h7FF0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 addr still", mem_addr, 64'h7FF0);
        chk("R10 sp held", sp, 64'h7FF8);
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R11 done stall", {63'd0, done}, 64'd1);
        chk("R10 sp after", sp, 64'h7FF0);
        @(negedge clk);
        chk("R11 done one cycle", {63'd0, done}, 64'd0);
        repeat (3) @(negedge clk);
        chk("R11 ignored req", 64'(req_cnt - r0), 64'd1);
        chk("R11 ignored rf", 64'(rf_cnt - f0), 64'd0);
        chk("R11 ignored sp", sp, 64'h7FF0);
    endtask

    task automatic t_calls;
        issue(4'd9, 64'h0, 16'hFFFD, 64'h1000);
        chk("R8 ret data", lw_data, 64'h1004);
        chk("R8 addr", lw_addr, 64'h7FE8);
        chk("R8 pc_we", {63'd0, pc_we}, 64'd1);
        chk("R8 target", pc_wdata, 64'hFF4);
        issue(4'd10, 64'h2000_0000, 16'h0005, 64'h2000);
        chk("R8 long data", lw_data, 64'h2004);
        chk("R8 long target", pc_wdata, 64'h2000_0014);
        chk("R8 long sp", sp, 64'h7FE0);
    endtask

    task automatic t_ret;
        rd_value = 64'h4444;
        issue(4'd11, 64'h0, 16'h0, 64'h0);
        chk("R9 addr", lw_addr, 64'h7FE0);
        chk("R9 pc", pc_wdata, 64'h4444);
        chk("R9 pc_we", {62'd0, pc_we, rf_we}, 64'd2);
        chk("R9 sp", sp, 64'h7FE8);
    endtask

    task automatic t_leave;
        rd_value = 64'h7FC0;
        issue(4'd7, 64'h0, 16'h0, 64'h0);
        chk("R6 addr", lw_addr, 64'h7FF8);
        chk("R6 sp", sp, 64'h8000);
        chk("R6 fp", fp, 64'h7FC0);
    endtask

    task automatic t_none;
        int r0 = req_cnt;
        issue(4'd0, 64'h1234, 16'h55, 64'h0);
        issue(4'd14, 64'h1234, 16'h55, 64'h0);
        chk("R12 no req", 64'(req_cnt - r0), 64'd0);
        chk("R12 sp", sp, 64'h8000);
        chk("R12 fp", fp, 64'h7FC0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_reg();
        t_push_imm();
        t_pop();
        t_reloc();
        t_enter();
        t_stall_ignore();
        t_calls();
        t_ret();
        t_leave();
        t_none();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule